// File: doc/BRIEF.md
# ADC Result Capture with Window and Crossing Compare

This block sits behind an ADC core and turns each finished conversion into a packed result word for the conversion sequence it belongs to. Two sequences are supported. Each has one result word, which is always overwritten by the newest result for that sequence. Next to the 12-bit sample, the word carries the following fields:
- a window classification against a low and a high threshold;
- a low-threshold crossing code, measured against the previous sample taken on the same channel;
- a valid flag;
- an overrun flag.

Software or a DMA engine reads a word through a one-cycle read port. A read returns the stored word and clears both of that word's flags. Each sequence has a reporting mode bit.
- In per-conversion mode (mode 0), a result that overwrites an unread word raises overrun.
- In end-of-sequence mode (mode 1), overrun is never raised. Instead, the block pulses a done line after the conversion marked as the last one of the sequence.

Top module: `adc_result_capture`

## Requirements
- R1: A strobe on `resValid` stores `resData` into the word of sequence `resSeq`. In that word the sample reads back in bits 15:4, and bits 3:0 and 29:20 read as zero.
- R2: Bits 17:16 hold the window code. 00 means inside (low <= sample <= high, so equality counts as inside), 01 means below the low threshold, and 10 means above the high threshold.
- R3: Bits 19:18 hold the crossing code, 10 for downward and 11 for upward. Downward means the previous sample on the channel was >= low and the new one is < low. Upward means the previous sample was < low and the new one is >= low. Otherwise the code is 00. The history is kept per channel and is shared by both sequences.
- R4: The first sample on a channel after reset reports crossing 00.
- R5: Bit 31 (valid) is set when a result is stored. It is cleared by a read of that word. A read of the other sequence's word leaves it unchanged.
- R6: In mode 0, bit 30 (overrun) is set when a result is stored while valid is still set and the word is not read in that same cycle. Overrun stays set until the word is read.
- R7: In mode 1, overrun is never set.
- R8: `seqDone[s]` is high for exactly the one cycle after a strobe for sequence s that has `resLast` set while that sequence is in mode 1. It never pulses in mode 0.
- R9: `rdData` takes the selected word in the cycle after `rdEn`, and holds it otherwise. If a read and a strobe for the same sequence fall in the same cycle, the read returns the old word, and the new result is stored with valid set and no overrun.
- R10: After reset, both words, `rdData` and `seqDone` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resValid | input | 1 | Conversion result strobe |
| resSeq | input | 1 | Sequence of the strobed result |
| resChan | input | CH_W | Channel of the strobed result |
| resData | input | RES_W | Conversion sample |
| resLast | input | 1 | Strobed result is the last of its sequence |
| thrLow | input | RES_W | Low threshold |
| thrHigh | input | RES_W | High threshold |
| seqMode | input | 2 | Per-sequence mode: 0 per conversion, 1 end of sequence |
| rdEn | input | 1 | Read request |
| rdSel | input | 1 | Sequence word selected for reading |
| rdData | output | 32 | Registered read data |
| seqDone | output | 2 | Per-sequence end-of-sequence pulse |

## Verification
The bench builds the block with four channels and the full 12-bit sample width. The small channel count means a sample sweep of more than a hundred values visits every channel many times. That brings every ordering of previous and new sample around the low threshold within reach, in both directions. Three threshold pairs are used: a narrow window, the full scale, and a zero-width window with both thresholds equal. Together they reach each equality boundary of the window code.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int SEQ_N = 2;

  typedef enum logic [1:0] {
    RNG_IN    = 2'b00,
    RNG_BELOW = 2'b01,
    RNG_ABOVE = 2'b10
  } rangeCode_e;

  typedef enum logic [1:0] {
    CRS_NONE = 2'b00,
    CRS_DOWN = 2'b10,
    CRS_UP   = 2'b11
  } crossCode_e;

  typedef struct packed {
    logic [SEQ_N-1:0] load;
    logic             capture;
  } ctrlStrobe_t;
endpackage

// File: rtl/adc_cap_ctrl.sv
module adc_cap_ctrl
  import adc_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValid,
  input  logic              resSeq,
  input  logic              resLast,
  input  logic [SEQ_N-1:0]  seqMode,
  input  logic              rdEn,
  input  logic              rdSel,
  output ctrlStrobe_t       strobe,
  output logic [SEQ_N-1:0]  validQ,
  output logic [SEQ_N-1:0]  ovrQ,
  output logic [SEQ_N-1:0]  doneQ
);
  logic [SEQ_N-1:0] loadSeq;
  logic [SEQ_N-1:0] rdHit;

  assign strobe.load    = loadSeq;
  assign strobe.capture = rdEn;

  for (genvar s = 0; s < SEQ_N; s++) begin : g_seq
    assign loadSeq[s] = resValid && (resSeq == 1'(s));
    assign rdHit[s]   = rdEn && (rdSel == 1'(s));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[s] <= 1'b0;
        ovrQ[s]   <= 1'b0;
        doneQ[s]  <= 1'b0;
      end else begin
        validQ[s] <= loadSeq[s] | (validQ[s] & ~rdHit[s]);
        ovrQ[s]   <= ~rdHit[s] & (ovrQ[s] | (loadSeq[s] & ~seqMode[s] & validQ[s]));
        doneQ[s]  <= loadSeq[s] & seqMode[s] & resLast;
      end
    end

    p_load_sets_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
      loadSeq[s] |=> validQ[s]);
    p_read_clears_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
      (rdHit[s] && !loadSeq[s]) |=> !validQ[s]);
    p_no_overrun_eos_r7: assert property (@(posedge clk) disable iff (!rstN)
      (seqMode[s] && !ovrQ[s]) |=> !ovrQ[s]);
    p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rstN)
      doneQ[s] |-> $past(resValid && resLast));
  end
endmodule

// File: rtl/adc_cap_dpath.sv
module adc_cap_dpath
  import adc_cap_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int NUM_CH = 12,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              resSeq,
  input  logic [CH_W-1:0]   resChan,
  input  logic [RES_W-1:0]  resData,
  input  logic [RES_W-1:0]  thrLow,
  input  logic [RES_W-1:0]  thrHigh,
  input  logic              rdSel,
  input  logic [SEQ_N-1:0]  validFlags,
  input  logic [SEQ_N-1:0]  ovrFlags,
  output logic [31:0]       rdData
);
  localparam int FIELD_W = 12;

  logic [RES_W-1:0] resQ   [SEQ_N];
  rangeCode_e       rangeQ [SEQ_N];
  crossCode_e       crossQ [SEQ_N];
  logic [RES_W-1:0] prevQ  [NUM_CH];
  logic [NUM_CH-1:0] seenQ;

  logic             chanOk;
  logic             prevSeen;
  logic [RES_W-1:0] prevVal;
  rangeCode_e       newRange;
  crossCode_e       newCross;
  logic [FIELD_W-1:0] selField;

  assign chanOk = 32'(resChan) < NUM_CH;

  always_comb begin
    prevSeen = 1'b0;
    prevVal  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (chanOk && 32'(resChan) == c) begin
        prevSeen = seenQ[c];
        prevVal  = prevQ[c];
      end
    end
    if (resData < thrLow)       newRange = RNG_BELOW;
    else if (resData > thrHigh) newRange = RNG_ABOVE;
    else                        newRange = RNG_IN;
    if (!prevSeen)                                  newCross = CRS_NONE;
    else if (prevVal >= thrLow && resData < thrLow) newCross = CRS_DOWN;
    else if (prevVal < thrLow && resData >= thrLow) newCross = CRS_UP;
    else                                            newCross = CRS_NONE;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevQ[c] <= '0;
        seenQ[c] <= 1'b0;
      end else if ((|strobe.load) && chanOk && 32'(resChan) == c) begin
        prevQ[c] <= resData;
        seenQ[c] <= 1'b1;
      end
    end
  end

  for (genvar s = 0; s < SEQ_N; s++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        resQ[s]   <= '0;
        rangeQ[s] <= RNG_IN;
        crossQ[s] <= CRS_NONE;
      end else if (strobe.load[s]) begin
        resQ[s]   <= resData;
        rangeQ[s] <= newRange;
        crossQ[s] <= newCross;
      end
    end

    p_below_not_up_r3: assert property (@(posedge clk) disable iff (!rstN)
      (rangeQ[s] == RNG_BELOW) |-> (crossQ[s] != CRS_UP));
    p_first_no_cross_r4: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.load[s] && !prevSeen) |=> (crossQ[s] == CRS_NONE));
  end

  assign selField = FIELD_W'(resQ[rdSel]);

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strobe.capture)
      rdData <= {validFlags[rdSel], ovrFlags[rdSel], 10'b0,
                 crossQ[rdSel], rangeQ[rdSel], selField, 4'b0};
  end
endmodule

// File: rtl/adc_result_capture.sv
module adc_result_capture
  import adc_cap_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int NUM_CH = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValid,
  input  logic              resSeq,
  input  logic [CH_W-1:0]   resChan,
  input  logic [RES_W-1:0]  resData,
  input  logic              resLast,
  input  logic [RES_W-1:0]  thrLow,
  input  logic [RES_W-1:0]  thrHigh,
  input  logic [1:0]        seqMode,
  input  logic              rdEn,
  input  logic              rdSel,
  output logic [31:0]       rdData,
  output logic [1:0]        seqDone
);
  ctrlStrobe_t      strobe;
  logic [SEQ_N-1:0] validQ;
  logic [SEQ_N-1:0] ovrQ;

  adc_cap_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resSeq(resSeq),
    .resLast(resLast), .seqMode(seqMode), .rdEn(rdEn), .rdSel(rdSel),
    .strobe(strobe), .validQ(validQ), .ovrQ(ovrQ), .doneQ(seqDone)
  );

  adc_cap_dpath #(.RES_W(RES_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .resSeq(resSeq),
    .resChan(resChan), .resData(resData), .thrLow(thrLow), .thrHigh(thrHigh),
    .rdSel(rdSel), .validFlags(validQ), .ovrFlags(ovrQ), .rdData(rdData)
  );
endmodule

// File: tb/test_adc_result_capture.sv
module test_adc_result_capture;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resValid = 1'b0;
  logic        resSeq = 1'b0;
  logic [1:0]  resChan = '0;
  logic [11:0] resData = '0;
  logic        resLast = 1'b0;
  logic [11:0] thrLow = '0;
  logic [11:0] thrHigh = '0;
  logic [1:0]  seqMode = '0;
  logic        rdEn = 1'b0;
  logic        rdSel = 1'b0;
  logic [31:0] rdData;
  logic [1:0]  seqDone;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  logic [11:0] mRes [2];
  logic [1:0]  mRng [2];
  logic [1:0]  mCrs [2];
  bit          mVal [2];
  bit          mOvr [2];
  int          mPrev [NCH];
  bit          mSeen [NCH];

  always #2 clk = ~clk;

  adc_result_capture #(.RES_W(12), .NUM_CH(NCH)) i_adc_result_capture (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resSeq(resSeq),
    .resChan(resChan), .resData(resData), .resLast(resLast),
    .thrLow(thrLow), .thrHigh(thrHigh), .seqMode(seqMode),
    .rdEn(rdEn), .rdSel(rdSel), .rdData(rdData), .seqDone(seqDone)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  function automatic logic [31:0] modelWord(int s);
    return {mVal[s], mOvr[s], 10'b0, mCrs[s], mRng[s], mRes[s], 4'b0};
  endfunction

  // One cycle: inputs set after a falling edge, results sampled at the next falling edge.
  task automatic step(bit st, bit sq, int ch, int v, bit last, bit rd, bit rs, string req);
    logic [31:0] expRd;
    logic [1:0]  expDone;
    int low;
    expRd = rdData;
    if (rd) begin
      expRd = modelWord(rs);
      mVal[rs] = 1'b0;
      mOvr[rs] = 1'b0;
    end
    expDone = '0;
    if (st) begin
      low = int'(thrLow);
      if (seqMode[sq] == 1'b0 && mVal[sq]) mOvr[sq] = 1'b1;
      mVal[sq] = 1'b1;
      mRes[sq] = 12'(v);
      if (v < low) mRng[sq] = 2'b01;
      else if (v > int'(thrHigh)) mRng[sq] = 2'b10;
      else mRng[sq] = 2'b00;
      if (!mSeen[ch]) mCrs[sq] = 2'b00;
      else if (mPrev[ch] >= low && v < low) mCrs[sq] = 2'b10;
      else if (mPrev[ch] < low && v >= low) mCrs[sq] = 2'b11;
      else mCrs[sq] = 2'b00;
      mPrev[ch] = v;
      mSeen[ch] = 1'b1;
      expDone[sq] = seqMode[sq] & last;
    end
    resValid = st; resSeq = sq; resChan = 2'(ch); resData = 12'(v);
    resLast = last; rdEn = rd; rdSel = rs;
    @(negedge clk);
    resValid = 1'b0; resLast = 1'b0; rdEn = 1'b0;
    if (rd) check(req, rdData, expRd);
    check("R8 seqDone", {30'b0, seqDone}, {30'b0, expDone});
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      mRes[s] = '0; mRng[s] = '0; mCrs[s] = '0; mVal[s] = 0; mOvr[s] = 0;
    end
    for (int c = 0; c < NCH; c++) begin
      mPrev[c] = 0; mSeen[c] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10: reset state
    check("R10 rdData", rdData, 32'h0);
    check("R10 seqDone", {30'b0, seqDone}, 32'h0);
    step(0, 0, 0, 0, 0, 1, 0, "R10 word0");
    step(0, 0, 0, 0, 0, 1, 1, "R10 word1");

    // R1 R2 R3 R4 R5: sweep of samples over three windows
    for (int t = 0; t < 3; t++) begin
      int lo, hi;
      lo = (t == 0) ? 100 : (t == 1) ? 0 : 2048;
      hi = (t == 0) ? 200 : (t == 1) ? 4095 : 2048;
      thrLow = 12'(lo); thrHigh = 12'(hi);
      for (int v = 0; v < 4096; v += 37) begin
        step(1, v[0], v % NCH, v, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 1, v[0], "R1 R2 R3 R4 R5 sweep");
      end
      for (int k = 0; k < 6; k++) begin
        int b;
        b = (k < 3) ? lo - 1 + k : hi - 1 + (k - 3);
        if (b >= 0 && b < 4096) begin
          step(1, k[0], k % NCH, b, 0, 0, 0, "R2");
          step(0, 0, 0, 0, 0, 1, k[0], "R2 R3 boundary");
        end
      end
    end

    // R3: explicit crossings on one channel around low = 100
    thrLow = 12'd100; thrHigh = 12'd300;
    step(1, 0, 2, 150, 0, 0, 0, "R3");
    step(1, 0, 2, 99, 0, 1, 0, "R3 pre-read");
    step(0, 0, 0, 0, 0, 1, 0, "R3 downward");
    step(1, 1, 2, 100, 0, 1, 1, "R3 pre-read");
    step(0, 0, 0, 0, 0, 1, 1, "R3 upward, shared history");

    // R5: reading the other sequence leaves valid alone
    step(1, 0, 1, 500, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 1, 1, "R5 other sequence read");
    step(0, 0, 0, 0, 0, 1, 0, "R5 valid still set");

    // R6: overrun in mode 0, sticky until read
    seqMode = 2'b00;
    step(1, 1, 0, 10, 0, 0, 0, "R6");
    step(1, 1, 1, 20, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 1, 1, "R6 overrun set");
    step(0, 0, 0, 0, 0, 1, 1, "R6 overrun cleared");

    // R9: read and strobe in the same cycle
    step(1, 1, 3, 700, 0, 0, 0, "R9");
    step(1, 1, 3, 800, 0, 1, 1, "R9 old word returned");
    step(0, 0, 0, 0, 0, 1, 1, "R9 new stored valid, no overrun");

    // R7 R8: end-of-sequence mode on sequence 0, per-conversion on sequence 1
    seqMode = 2'b01;
    step(1, 0, 0, 1000, 0, 0, 0, "R8");
    step(1, 0, 1, 1100, 0, 0, 0, "R8");
    step(1, 0, 2, 1200, 1, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 0, "R7 no overrun in end-of-sequence mode");
    step(1, 1, 0, 1300, 1, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 1, "R8 mode 0 no done");

    summary();
  end
endmodule